// File: doc/BRIEF.md
# Keyboard and Display Register Interface

This block sits between a 16-bit processor bus and two character devices: a keyboard that delivers 8-bit codes and a display that consumes them. It claims four word addresses, starting at a base of 0xFE00 with a stride of two. When the bus address matches one of them, the block supplies the read data to the processor's memory data register in place of memory, and it keeps bus writes from reaching memory. Every other address passes straight through to memory.

Each device has a status register and a data register. Bit 15 of a status register is a handshake flag. Bit 14 is an interrupt-enable bit that software can write. The keyboard side holds one character at a time. While an unread character is held, new keystrokes are thrown away; reading the data register frees the slot. The display side takes one character at a time. A write to its data register starts an output beat. The block then reports ready again a programmable number of cycles after the display takes the beat. Each device drives its own interrupt request.

Both character paths use valid/ready. The display path obeys back-pressure: a beat stays valid with stable data until the sink raises `dout_ready`. The keyboard path cannot stall a typist, so `kin_ready` low means a presented beat is discarded, not held. The source never has to wait for `kin_ready`.

Top module: `kbd_disp_mmio`

## Requirements
- R1: The block decodes four exact word addresses: 0xFE00 keyboard status, 0xFE02 keyboard data, 0xFE04 display status and 0xFE06 display data. On any of them `dev_sel` is 1, `rdata` carries the register and `mem_we`/`mem_re` are 0. On any other address `dev_sel` is 0, `rdata` equals `mem_rdata`, `mem_we` follows `bus_wr` and `mem_re` follows `bus_rd`.
- R2: A keyboard beat (`kin_valid` and `kin_ready` both 1 at a clock edge) stores the code in bits [7:0] of keyboard data, with bits [15:8] reading zero. It also sets keyboard status bit 15 after that edge.
- R3: While keyboard status bit 15 is 1, `kin_ready` is 0 and presented codes are discarded; the stored code does not change.
- R4: A bus read of keyboard data clears keyboard status bit 15 at that edge, so `kin_ready` returns to 1.
- R5: After reset, display status bit 15 is 1. A write to display data while that bit is 1 raises `dout_valid` with bits [7:0] of the write on `dout_data`, and it clears bit 15. Display data reads back the last accepted code in bits [7:0].
- R6: A write to display data while display status bit 15 is 0 has no effect: no new beat, and the stored code is unchanged.
- R7: While `dout_valid` is 1 and `dout_ready` is 0, `dout_valid` stays 1 and `dout_data` stays stable.
- R8: Display status bit 15 returns to 1 `disp_latency` cycles after the edge at which the display beat is taken (at that same edge when `disp_latency` is 0).
- R9: Software writes to either status register change only bit 14. Bit 15 is not affected by them.
- R10: `kbd_irq` is keyboard status bit 15 AND bit 14, and `disp_irq` is display status bit 15 AND bit 14.
- R11: After reset, keyboard status and keyboard data read 0x0000, display status reads 0x8000, both interrupt requests are 0 and `dout_valid` is 0.
- R12: Bus writes to keyboard data have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Processor bus address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| mem_rdata | input | 16 | Read data returned by memory |
| rdata | output | 16 | Data to the memory data register |
| dev_sel | output | 1 | Decode hit; selects device data at the read mux |
| mem_we | output | 1 | Write enable passed on to memory |
| mem_re | output | 1 | Read enable passed on to memory |
| kin_valid | input | 1 | Keyboard code present |
| kin_data | input | 8 | Keyboard code |
| kin_ready | output | 1 | Code will be taken this cycle; if 0, a presented code is dropped |
| dout_valid | output | 1 | Display beat pending |
| dout_data | output | 8 | Display code |
| dout_ready | input | 1 | Display accepts the beat |
| disp_latency | input | 8 | Cycles from beat taken to display ready |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |

## Verification
If the keyboard flag is stuck high, `kin_ready` stays low and the status word reads 0x8000 in the cycle after the flag should have cleared. If the flag is stuck low, a second code overwrites the first, and the next data read shows the wrong character. A bad display ready flag shows as a beat sent from a write that should have been dropped. It can also show as a status bit 15 that rises one or more cycles off the programmed latency, which a status read in every cycle after the handshake exposes. A decode fault shows the same cycle, as `rdata` showing memory data or `mem_we` leaking on a device address.

// File: rtl/kdi_pkg.sv
package kdi_pkg;
  localparam int RDY_BIT = 15;
  localparam int IE_BIT  = 14;
  localparam int NUM_REGS = 4;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_KSTAT = 3'd1,
    SEL_KDATA = 3'd2,
    SEL_DSTAT = 3'd3,
    SEL_DDATA = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/kdi_decode.sv
module kdi_decode
  import kdi_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE_ADDR = 16'hFE00,
  parameter int STRIDE = 2
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel,
  output logic          hit
);
  logic [NUM_REGS-1:0] match;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_match
      localparam logic [AW-1:0] SLOT = AW'(BASE_ADDR + AW'(g * STRIDE));
      assign match[g] = (addr == SLOT);
    end
  endgenerate

  always_comb begin
    sel = SEL_NONE;
    unique case (1'b1)
      match[0]: sel = SEL_KSTAT;
      match[1]: sel = SEL_KDATA;
      match[2]: sel = SEL_DSTAT;
      match[3]: sel = SEL_DDATA;
      default:  sel = SEL_NONE;
    endcase
  end

  assign hit = |match;
endmodule

// File: rtl/kdi_in_port.sv
module kdi_in_port
  import kdi_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kin_valid,
  input  logic [CW-1:0] kin_data,
  output logic          kin_ready,
  input  logic          data_rd,
  input  logic          stat_wr,
  input  logic          wr_ie,
  output logic [DW-1:0] stat_word,
  output logic [DW-1:0] data_word,
  output logic          irq
);
  logic          full_q;
  logic          ie_q;
  logic [CW-1:0] code_q;
  logic          take;

  assign kin_ready = !full_q;
  assign take      = kin_valid && kin_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ie_q   <= 1'b0;
      code_q <= '0;
    end else begin
      if (take) begin
        code_q <= kin_data;
        full_q <= 1'b1;
      end else if (data_rd) begin
        full_q <= 1'b0;
      end
      if (stat_wr) ie_q <= wr_ie;
    end
  end

  always_comb begin
    stat_word         = '0;
    stat_word[RDY_BIT] = full_q;
    stat_word[IE_BIT]  = ie_q;
  end

  assign data_word = DW'(code_q);
  assign irq       = full_q && ie_q;
endmodule

// File: rtl/kdi_out_port.sv
module kdi_out_port
  import kdi_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic [CW-1:0]    wr_code,
  input  logic             stat_wr,
  input  logic             wr_ie,
  input  logic [LAT_W-1:0] latency,
  output logic             dout_valid,
  output logic [CW-1:0]    dout_data,
  input  logic             dout_ready,
  output logic [DW-1:0]    stat_word,
  output logic [DW-1:0]    data_word,
  output logic             irq
);
  logic             rdy_q;
  logic             ie_q;
  logic             busy_q;
  logic             vld_q;
  logic [CW-1:0]    code_q;
  logic [LAT_W-1:0] cnt_q;
  logic             accept;
  logic             handoff;

  assign accept  = data_wr && rdy_q;
  assign handoff = vld_q && dout_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b1;
      ie_q   <= 1'b0;
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (accept) begin
        code_q <= wr_code;
        vld_q  <= 1'b1;
        rdy_q  <= 1'b0;
      end
      if (handoff) begin
        vld_q <= 1'b0;
        if (latency == '0) begin
          rdy_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= latency;
        end
      end
      if (busy_q) begin
        if (cnt_q == LAT_W'(1)) begin
          busy_q <= 1'b0;
          rdy_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - LAT_W'(1);
        end
      end
      if (stat_wr) ie_q <= wr_ie;
    end
  end

  always_comb begin
    stat_word          = '0;
    stat_word[RDY_BIT] = rdy_q;
    stat_word[IE_BIT]  = ie_q;
  end

  assign data_word  = DW'(code_q);
  assign dout_valid = vld_q;
  assign dout_data  = code_q;
  assign irq        = rdy_q && ie_q;
endmodule

// File: rtl/kbd_disp_mmio.sv
module kbd_disp_mmio
  import kdi_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int LAT_W = 8,
  parameter logic [AW-1:0] BASE_ADDR = 16'hFE00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    rdata,
  output logic             dev_sel,
  output logic             mem_we,
  output logic             mem_re,
  input  logic             kin_valid,
  input  logic [CW-1:0]    kin_data,
  output logic             kin_ready,
  output logic             dout_valid,
  output logic [CW-1:0]    dout_data,
  input  logic             dout_ready,
  input  logic [LAT_W-1:0] disp_latency,
  output logic             kbd_irq,
  output logic             disp_irq
);
  reg_sel_e      sel;
  logic          hit;
  logic [DW-1:0] k_stat, k_data, d_stat, d_data;

  kdi_decode #(.AW(AW), .BASE_ADDR(BASE_ADDR), .STRIDE(2)) u_dec (
    .addr(bus_addr), .sel(sel), .hit(hit)
  );

  kdi_in_port #(.DW(DW), .CW(CW)) u_kbd (
    .clk(clk), .rst_n(rst_n),
    .kin_valid(kin_valid), .kin_data(kin_data), .kin_ready(kin_ready),
    .data_rd(bus_rd && sel == SEL_KDATA),
    .stat_wr(bus_wr && sel == SEL_KSTAT),
    .wr_ie(bus_wdata[IE_BIT]),
    .stat_word(k_stat), .data_word(k_data), .irq(kbd_irq)
  );

  kdi_out_port #(.DW(DW), .CW(CW), .LAT_W(LAT_W)) u_disp (
    .clk(clk), .rst_n(rst_n),
    .data_wr(bus_wr && sel == SEL_DDATA),
    .wr_code(bus_wdata[CW-1:0]),
    .stat_wr(bus_wr && sel == SEL_DSTAT),
    .wr_ie(bus_wdata[IE_BIT]),
    .latency(disp_latency),
    .dout_valid(dout_valid), .dout_data(dout_data), .dout_ready(dout_ready),
    .stat_word(d_stat), .data_word(d_data), .irq(disp_irq)
  );

  always_comb begin
    unique case (sel)
      SEL_KSTAT: rdata = k_stat;
      SEL_KDATA: rdata = k_data;
      SEL_DSTAT: rdata = d_stat;
      SEL_DDATA: rdata = d_data;
      default:   rdata = mem_rdata;
    endcase
  end

  assign dev_sel = hit;
  assign mem_we  = bus_wr && !hit;
  assign mem_re  = bus_rd && !hit;
endmodule

// File: rtl/kdi_checker.sv
module kdi_checker #(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter logic [AW-1:0] BASE_ADDR = 16'hFE00
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          dev_sel,
  input logic          mem_we,
  input logic          kin_valid,
  input logic          kin_ready,
  input logic          dout_valid,
  input logic [CW-1:0] dout_data,
  input logic          dout_ready,
  input logic          kbd_irq
);
  localparam logic [AW-1:0] KDATA_A = AW'(BASE_ADDR + AW'(2));
  localparam logic [AW-1:0] DDATA_A = AW'(BASE_ADDR + AW'(6));

  p_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[AW-1:3] != BASE_ADDR[AW-1:3]) |-> (!dev_sel && (mem_we == bus_wr)));

  p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kin_valid && kin_ready) |=> !kin_ready);

  p_hold_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!kin_ready && !(bus_rd && bus_addr == KDATA_A)) |=> !kin_ready);

  p_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!kin_ready && bus_rd && bus_addr == KDATA_A) |=> kin_ready);

  p_busy_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready && bus_wr && bus_addr == DDATA_A) |=> $stable(dout_data));

  p_backpressure_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

  p_irq_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_irq |-> !kin_ready);
endmodule

bind kbd_disp_mmio kdi_checker #(.AW(AW), .CW(CW), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .dev_sel(dev_sel), .mem_we(mem_we), .kin_valid(kin_valid), .kin_ready(kin_ready),
  .dout_valid(dout_valid), .dout_data(dout_data), .dout_ready(dout_ready),
  .kbd_irq(kbd_irq)
);

// File: tb/kbd_disp_mmio_tb.sv
module kbd_disp_mmio_tb;
  localparam logic [15:0] A_KS = 16'hFE00;
  localparam logic [15:0] A_KD = 16'hFE02;
  localparam logic [15:0] A_DS = 16'hFE04;
  localparam logic [15:0] A_DD = 16'hFE06;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0, mem_rdata = '0;
  logic [15:0] rdata;
  logic        dev_sel, mem_we, mem_re;
  logic        kin_valid = 1'b0;
  logic [7:0]  kin_data = '0;
  logic        kin_ready, dout_valid;
  logic [7:0]  dout_data;
  logic        dout_ready = 1'b0;
  logic [7:0]  disp_latency = 8'd3;
  logic        kbd_irq, disp_irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  kbd_disp_mmio u_dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic peek(logic [15:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    bus_addr = a;
    bus_rd = 1'b1;
    #1;
    d = rdata;
    cyc();
    bus_rd = 1'b0;
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] v);
    bus_addr = a;
    bus_wdata = v;
    bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic key(logic [7:0] c);
    kin_valid = 1'b1;
    kin_data = c;
    cyc();
    kin_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    peek(A_KS, d); chk("R11 kstat", d, 16'h0000);
    peek(A_KD, d); chk("R11 kdata", d, 16'h0000);
    peek(A_DS, d); chk("R11 dstat", d, 16'h8000);
    chk("R11 irqs/valid", {13'd0, kbd_irq, disp_irq, dout_valid}, 16'h0000);
  endtask

  task automatic t_decode();
    mem_rdata = 16'hBEEF;
    bus_addr = 16'h1000; bus_wr = 1'b1; #1;
    chk("R1 mem rdata", rdata, 16'hBEEF);
    chk("R1 mem sel/we", {14'd0, dev_sel, mem_we}, 16'h0001);
    bus_addr = A_DS; #1;
    chk("R1 hit sel/we", {14'd0, dev_sel, mem_we}, 16'h0002);
    chk("R1 hit rdata", rdata, 16'h8000);
    bus_wr = 1'b0; bus_rd = 1'b1;
    bus_addr = 16'hFE01; #1;
    chk("R1 odd miss", {dev_sel, mem_re, rdata[13:0]}, {2'b01, 14'h3EEF});
    bus_addr = 16'hFE08; #1;
    chk("R1 above miss", {15'd0, dev_sel}, 16'h0000);
    bus_rd = 1'b0;
  endtask

  task automatic t_input();
    logic [15:0] d;
    chk("R2 ready before", {15'd0, kin_ready}, 16'h0001);
    key(8'h41);
    peek(A_KS, d); chk("R2 flag set", d, 16'h8000);
    chk("R3 ready low", {15'd0, kin_ready}, 16'h0000);
    rd(A_KD, d); chk("R2 data", d, 16'h0041);
    peek(A_KS, d); chk("R4 flag clear", d, 16'h0000);
    chk("R4 ready back", {15'd0, kin_ready}, 16'h0001);
  endtask

  task automatic t_drop();
    logic [15:0] d;
    key(8'h42);
    key(8'h43);
    key(8'h44);
    rd(A_KD, d); chk("R3 first kept", d, 16'h0042);
    peek(A_KS, d); chk("R4 cleared after drop", d, 16'h0000);
  endtask

  task automatic t_output();
    logic [15:0] d;
    dout_ready = 1'b0;
    wr(A_DD, 16'h1234);
    chk("R5 beat", {7'd0, dout_valid, dout_data}, 16'h0134);
    peek(A_DS, d); chk("R5 busy", d, 16'h0000);
    cyc(); cyc(); cyc();
    chk("R7 held", {7'd0, dout_valid, dout_data}, 16'h0134);
    wr(A_DD, 16'h0055);
    chk("R6 busy write", {7'd0, dout_valid, dout_data}, 16'h0134);
    dout_ready = 1'b1;
    cyc();
    chk("R7 taken", {15'd0, dout_valid}, 16'h0000);
    peek(A_DS, d); chk("R8 lat0", d, 16'h0000);
    cyc(); peek(A_DS, d); chk("R8 lat1", d, 16'h0000);
    cyc(); peek(A_DS, d); chk("R8 lat2", d, 16'h0000);
    cyc(); peek(A_DS, d); chk("R8 lat3", d, 16'h8000);
    chk("R6 no extra beat", {15'd0, dout_valid}, 16'h0000);
    peek(A_DD, d); chk("R6 code kept", d, 16'h0034);
    disp_latency = 8'd0;
    wr(A_DD, 16'h0066);
    cyc();
    peek(A_DS, d); chk("R8 zero latency", d, 16'h8000);
    chk("R5 second beat gone", {15'd0, dout_valid}, 16'h0000);
    dout_ready = 1'b0;
    disp_latency = 8'd3;
  endtask

  task automatic t_status();
    logic [15:0] d;
    wr(A_KS, 16'hFFFF);
    peek(A_KS, d); chk("R9 kbd ie only", d, 16'h4000);
    chk("R10 kbd no irq", {15'd0, kbd_irq}, 16'h0000);
    key(8'h5A);
    chk("R10 kbd irq", {15'd0, kbd_irq}, 16'h0001);
    wr(A_KS, 16'h0000);
    peek(A_KS, d); chk("R9 flag kept", d, 16'h8000);
    chk("R10 kbd masked", {15'd0, kbd_irq}, 16'h0000);
    wr(A_DS, 16'h4000);
    peek(A_DS, d); chk("R9 disp ie", d, 16'hC000);
    chk("R10 disp irq", {15'd0, disp_irq}, 16'h0001);
    wr(A_DS, 16'h0000);
    peek(A_DS, d); chk("R9 disp rdy kept", d, 16'h8000);
    chk("R10 disp masked", {15'd0, disp_irq}, 16'h0000);
  endtask

  task automatic t_kdata_write();
    logic [15:0] d;
    wr(A_KD, 16'h00FF);
    peek(A_KS, d); chk("R12 kstat", d, 16'h8000);
    rd(A_KD, d); chk("R12 kdata", d, 16'h005A);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_decode();
    t_input();
    t_drop();
    t_output();
    t_status();
    t_kdata_write();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule